// File: doc/BRIEF.md
# Five-Level Priority Interrupt Sequencer

This block decides which of five program execution levels runs. Level 1 has the highest priority and level 5 the lowest. Level 5 is the background level. Levels 1 to 4 run when a request for them has been latched and they are not masked. A level that becomes eligible preempts any running level with a higher number. An exit strobe from the running level hands control back to the next level that is still active. Each level owns a private two-bit condition pair (C, Z). Software reads and writes only the pair of the running level, so preemption and return never disturb a suspended level's pair.

Requests are held in two readable groups. The first group holds the I/O-check request for level 1. This request is raised by a dedicated input, and also by an input instruction that addresses a register number outside the defined range. In that case the instruction's address is captured as well. The second group holds a diagnostic level-2 request, program requests for levels 3 and 4, and a service request for level 4. The sequencer itself sets the service request when level 5 exits. Each time level 1 takes over, a utility status register records which program level was preempted, together with level 5's condition pair when that was the level interrupted.

Top module: `prio_level_seq`

## Requirements
- R1: After reset, `curLevel` is 5, both request groups and `utilStat` read zero, `czOut` is 00, `lastAddr` is zero and no level is masked.
- R2: `curLevel` shows the lowest-numbered level that is active and unmasked, decided combinationally. Level 5 is eligible whenever it is unmasked. The value 0 means no level is eligible. A level whose request is set by a `reqSet` pulse becomes active at the second rising edge after the pulse begins. `reqSet`/`reqClr` bit 0 is the level-1 I/O check, bit 1 the diagnostic level 2, bit 2 the program level 3, bit 3 the program level 4 and bit 4 the service level 4.
- R3: `grp1IoChk` reflects request bit 0. `grp2` bits 0..3 reflect request bits 1..4. A `reqClr` bit clears its request at the next edge, and a set in the same cycle wins over a clear.
- R4: `maskWr` loads `maskData`, whose bit k masks level k+2. A masked level never appears on `curLevel`, and a pending request does not activate it. After unmasking, the pending request activates it at the next edge. Level 1 cannot be masked.
- R5: `czWr` writes `czData` into the running level's private pair at the next edge. `czOut` shows the running level's pair, or 00 when no level runs. Preemption and return leave every other level's pair unchanged.
- R6: `exitLvl` clears the running level's active flag at the next edge, and `curLevel` then shows the next eligible level. If that level's request is still set, it stays active instead, so level 5 regains control only after the level-4 program request is cleared.
- R7: `exitLvl` while level 5 runs sets the service level-4 request (`grp2[3]`) at the next edge. Level 4 becomes current one edge later, and `reqClr` bit 4 clears the request.
- R8: At the edge where level 1 becomes active, `utilStat[3:0]` is loaded with a one-hot mark of the preempted level (bit 0 level 2 through bit 3 level 5). `utilStat[5:4]` is loaded with level 5's pair if level 5 was preempted, and with 00 otherwise.
- R9: An `inStrobe` with `inAddr` greater than or equal to `VALID_REGS` (default 0x60) sets the level-1 request and captures `instrAddr` into `lastAddr` at the next edge. An address below that limit changes neither.
- R10: A chain of preemptions 4, 3, 2, 1 followed by exits returns through 2, 3, 4 to 5, and each level shows on return the pair it held when it was preempted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqSet | input | 5 | Request set strobes, one per request bit |
| reqClr | input | 5 | Request clear strobes, one per request bit |
| ioCheck | input | 1 | Raises the level-1 I/O-check request |
| maskWr | input | 1 | Load strobe for the mask register |
| maskData | input | 4 | Mask for levels 2..5 (bit 0 = level 2) |
| exitLvl | input | 1 | Exit strobe from the running level |
| czWr | input | 1 | Write strobe for the running level's condition pair |
| czData | input | 2 | Condition pair to write (bit 1 = C, bit 0 = Z) |
| inStrobe | input | 1 | An input instruction is executing |
| inAddr | input | REG_W | Register number addressed by the input instruction |
| instrAddr | input | ADDR_W | Address of the executing instruction |
| curLevel | output | 3 | Running level, 1..5, or 0 for none |
| czOut | output | 2 | Running level's condition pair |
| grp1IoChk | output | 1 | Request group 1: I/O-check level 1 |
| grp2 | output | 4 | Request group 2: diag L2, prog L3, prog L4, service L4 |
| utilStat | output | 6 | Preempted-level marks and level-5 condition pair |
| lastAddr | output | ADDR_W | Address of the last instruction with an undefined register number |

## Verification
Several properties are checked on every cycle. A latched level-1 request always owns the sequencer. A masked level never runs. The running level's pair changes only after a write. A level-5 exit always raises the service request. An undefined input address always lands in `lastAddr`. The entry of level 1 over level 5 always marks the utility register. Whether each suspended level's pair survives a full preemption chain and its unwinding, whether a still-pending request keeps a level alive across its exit, and how masking interacts with several simultaneous requests are shown only by the bench's scenarios and arbitration vectors.

// File: rtl/plseq_pkg.sv
package plseq_pkg;
  localparam int NUM_LVL   = 5;
  localparam int NUM_REQ   = 5;
  localparam int NUM_MASK  = NUM_LVL - 1;
  localparam int UTIL_W    = NUM_MASK + 2;

  typedef logic [2:0] lvl_t;

  typedef struct packed {
    logic czWrEn;
    logic l1Entry;
    logic l5Exit;
    lvl_t curLvl;
  } seq_strobe_t;
endpackage

// File: rtl/plseq_ctrl.sv
module plseq_ctrl
  import plseq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_MASK-1:0] reqPend,
  input  logic                maskWr,
  input  logic [NUM_MASK-1:0] maskData,
  input  logic                exitLvl,
  input  logic                czWr,
  output seq_strobe_t         strb,
  output lvl_t                curLevel,
  output logic [NUM_MASK-1:0] maskQ
);
  // act[i] is the active flag of level i+1; level 5 has no flag
  logic [NUM_MASK-1:0] act;
  logic [NUM_MASK-1:0] actNext;
  logic [NUM_LVL-1:0]  maskFull;
  logic [NUM_LVL-1:0]  elig;
  lvl_t                cur;

  assign maskFull = {maskQ, 1'b0};

  always_comb begin
    for (int i = 0; i < NUM_MASK; i++) elig[i] = act[i] & ~maskFull[i];
    elig[NUM_LVL-1] = ~maskFull[NUM_LVL-1];
  end

  always_comb begin
    cur = '0;
    for (int i = NUM_LVL-1; i >= 0; i--) begin
      if (elig[i]) cur = lvl_t'(i + 1);
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_MASK; i++) begin
      actNext[i] = (act[i] & ~(exitLvl && (cur == lvl_t'(i + 1))))
                 | (reqPend[i] & ~maskFull[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      act   <= '0;
      maskQ <= '0;
    end else begin
      act <= actNext;
      if (maskWr) maskQ <= maskData;
    end
  end

  assign curLevel     = cur;
  assign strb.czWrEn  = czWr && (cur != '0);
  assign strb.l1Entry = reqPend[0] && !act[0];
  assign strb.l5Exit  = exitLvl && (cur == lvl_t'(NUM_LVL));
  assign strb.curLvl  = cur;
endmodule

// File: rtl/plseq_dpath.sv
module plseq_dpath
  import plseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int REG_W      = 8,
  parameter int VALID_REGS = 96
) (
  input  logic                clk,
  input  logic                rstN,
  input  seq_strobe_t         strb,
  input  logic [NUM_REQ-1:0]  reqSet,
  input  logic [NUM_REQ-1:0]  reqClr,
  input  logic                ioCheck,
  input  logic                inStrobe,
  input  logic [REG_W-1:0]    inAddr,
  input  logic [ADDR_W-1:0]   instrAddr,
  input  logic [1:0]          czData,
  output logic [NUM_MASK-1:0] reqPend,
  output logic                grp1IoChk,
  output logic [3:0]          grp2,
  output logic [1:0]          czOut,
  output logic [UTIL_W-1:0]   utilStat,
  output logic [ADDR_W-1:0]   lastAddr
);
  logic [NUM_REQ-1:0]   reqQ;
  logic [NUM_REQ-1:0]   reqHw;
  logic                 badIn;
  logic [2*NUM_LVL-1:0] czFlat;
  logic [UTIL_W-1:0]    utilQ;
  logic [ADDR_W-1:0]    lastQ;

  assign badIn = inStrobe && (int'(inAddr) >= VALID_REGS);
  assign reqHw = {strb.l5Exit, 3'b000, ioCheck | badIn};

  always_ff @(posedge clk) begin
    if (!rstN) reqQ <= '0;
    else       reqQ <= (reqQ & ~reqClr) | reqSet | reqHw;
  end

  // level 4 runs for either its program request or its service request
  assign reqPend = {reqQ[3] | reqQ[4], reqQ[2], reqQ[1], reqQ[0]};

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_czBank
    logic [1:0] bankQ;
    always_ff @(posedge clk) begin
      if (!rstN) bankQ <= '0;
      else if (strb.czWrEn && (strb.curLvl == lvl_t'(g + 1))) bankQ <= czData;
    end
    assign czFlat[2*g +: 2] = bankQ;
  end

  always_comb begin
    czOut = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (strb.curLvl == lvl_t'(i + 1)) czOut = czFlat[2*i +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      utilQ <= '0;
      lastQ <= '0;
    end else begin
      if (strb.l1Entry) begin
        case (strb.curLvl)
          3'd2:    utilQ <= {2'b00, 4'b0001};
          3'd3:    utilQ <= {2'b00, 4'b0010};
          3'd4:    utilQ <= {2'b00, 4'b0100};
          3'd5:    utilQ <= {czFlat[2*(NUM_LVL-1) +: 2], 4'b1000};
          default: utilQ <= utilQ;
        endcase
      end
      if (badIn) lastQ <= instrAddr;
    end
  end

  assign grp1IoChk = reqQ[0];
  assign grp2      = reqQ[4:1];
  assign utilStat  = utilQ;
  assign lastAddr  = lastQ;
endmodule

// File: rtl/prio_level_seq.sv
module prio_level_seq
  import plseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int REG_W      = 8,
  parameter int VALID_REGS = 96
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        reqSet,
  input  logic [4:0]        reqClr,
  input  logic              ioCheck,
  input  logic              maskWr,
  input  logic [3:0]        maskData,
  input  logic              exitLvl,
  input  logic              czWr,
  input  logic [1:0]        czData,
  input  logic              inStrobe,
  input  logic [REG_W-1:0]  inAddr,
  input  logic [ADDR_W-1:0] instrAddr,
  output logic [2:0]        curLevel,
  output logic [1:0]        czOut,
  output logic              grp1IoChk,
  output logic [3:0]        grp2,
  output logic [5:0]        utilStat,
  output logic [ADDR_W-1:0] lastAddr
);
  seq_strobe_t         strb;
  logic [NUM_MASK-1:0] reqPend;
  logic [NUM_MASK-1:0] maskQ;

  plseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqPend  (reqPend),
    .maskWr   (maskWr),
    .maskData (maskData),
    .exitLvl  (exitLvl),
    .czWr     (czWr),
    .strb     (strb),
    .curLevel (curLevel),
    .maskQ    (maskQ)
  );

  plseq_dpath #(
    .ADDR_W     (ADDR_W),
    .REG_W      (REG_W),
    .VALID_REGS (VALID_REGS)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqSet    (reqSet),
    .reqClr    (reqClr),
    .ioCheck   (ioCheck),
    .inStrobe  (inStrobe),
    .inAddr    (inAddr),
    .instrAddr (instrAddr),
    .czData    (czData),
    .reqPend   (reqPend),
    .grp1IoChk (grp1IoChk),
    .grp2      (grp2),
    .czOut     (czOut),
    .utilStat  (utilStat),
    .lastAddr  (lastAddr)
  );
endmodule

// File: rtl/plseq_checker.sv
module plseq_checker #(
  parameter int ADDR_W     = 16,
  parameter int REG_W      = 8,
  parameter int VALID_REGS = 96
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        curLevel,
  input logic [3:0]        maskQ,
  input logic              grp1IoChk,
  input logic [3:0]        grp2,
  input logic              czWr,
  input logic [1:0]        czOut,
  input logic              exitLvl,
  input logic              inStrobe,
  input logic [REG_W-1:0]  inAddr,
  input logic [ADDR_W-1:0] instrAddr,
  input logic [ADDR_W-1:0] lastAddr,
  input logic [5:0]        utilStat
);
  AST_L1_OWNS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(grp1IoChk) && grp1IoChk) |-> (curLevel == 3'd1)); // R2

  AST_MASKED_NEVER_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (curLevel >= 3'd2) |-> !maskQ[curLevel - 3'd2]); // R4

  AST_CZ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((curLevel == $past(curLevel)) && !$past(czWr)) |-> (czOut == $past(czOut))); // R5

  AST_SVC_AFTER_L5_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (exitLvl && (curLevel == 3'd5)) |=> grp2[3]); // R7

  AST_UTIL_MARKS_L5: assert property (@(posedge clk) disable iff (!rstN)
    (($past(curLevel) == 3'd5) && (curLevel == 3'd1)) |-> utilStat[3]); // R8

  AST_BAD_INPUT_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (inStrobe && (int'(inAddr) >= VALID_REGS)) |=> ((lastAddr == $past(instrAddr)) && grp1IoChk)); // R9
endmodule

bind prio_level_seq plseq_checker #(
  .ADDR_W     (ADDR_W),
  .REG_W      (REG_W),
  .VALID_REGS (VALID_REGS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .curLevel  (curLevel),
  .maskQ     (maskQ),
  .grp1IoChk (grp1IoChk),
  .grp2      (grp2),
  .czWr      (czWr),
  .czOut     (czOut),
  .exitLvl   (exitLvl),
  .inStrobe  (inStrobe),
  .inAddr    (inAddr),
  .instrAddr (instrAddr),
  .lastAddr  (lastAddr),
  .utilStat  (utilStat)
);

// File: tb/prio_level_seq_tb.sv
module prio_level_seq_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  reqSet, reqClr;
  logic        ioCheck, maskWr, exitLvl, czWr, inStrobe;
  logic [3:0]  maskData;
  logic [1:0]  czData;
  logic [7:0]  inAddr;
  logic [15:0] instrAddr;
  logic [2:0]  curLevel;
  logic [1:0]  czOut;
  logic        grp1IoChk;
  logic [3:0]  grp2;
  logic [5:0]  utilStat;
  logic [15:0] lastAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  prio_level_seq u_dut (
    .clk(clk), .rstN(rstN), .reqSet(reqSet), .reqClr(reqClr), .ioCheck(ioCheck),
    .maskWr(maskWr), .maskData(maskData), .exitLvl(exitLvl), .czWr(czWr),
    .czData(czData), .inStrobe(inStrobe), .inAddr(inAddr), .instrAddr(instrAddr),
    .curLevel(curLevel), .czOut(czOut), .grp1IoChk(grp1IoChk), .grp2(grp2),
    .utilStat(utilStat), .lastAddr(lastAddr)
  );

  // vector: {mask[3:0], reqSet[4:0], expected curLevel[2:0]}
  localparam logic [11:0] VEC [10] = '{
    {4'b0000, 5'b00000, 3'd5},
    {4'b0000, 5'b01000, 3'd4},
    {4'b0000, 5'b01100, 3'd3},
    {4'b0000, 5'b01110, 3'd2},
    {4'b0000, 5'b11111, 3'd1},
    {4'b0001, 5'b01010, 3'd4},
    {4'b0110, 5'b01100, 3'd5},
    {4'b1000, 5'b00000, 3'd0},
    {4'b1111, 5'b00001, 3'd1},
    {4'b0000, 5'b10000, 3'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; reqSet = '0; reqClr = '0; ioCheck = 0; maskWr = 0; maskData = '0;
    exitLvl = 0; czWr = 0; czData = '0; inStrobe = 0; inAddr = '0; instrAddr = '0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic pSet(input logic [4:0] v);
    reqSet = v; step(1); reqSet = '0;
  endtask
  task automatic pClr(input logic [4:0] v);
    reqClr = v; step(1); reqClr = '0;
  endtask
  task automatic pExit();
    exitLvl = 1; step(1); exitLvl = 0;
  endtask
  task automatic pCz(input logic [1:0] d);
    czWr = 1; czData = d; step(1); czWr = 0;
  endtask
  task automatic pMask(input logic [3:0] m);
    maskWr = 1; maskData = m; step(1); maskWr = 0;
  endtask
  task automatic pIo();
    ioCheck = 1; step(1); ioCheck = 0;
  endtask
  task automatic pIn(input logic [7:0] a, input logic [15:0] ia);
    inStrobe = 1; inAddr = a; instrAddr = ia; step(1); inStrobe = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1 curLevel", curLevel, 5);
    chk("R1 grp", {grp1IoChk, grp2}, 0);
    chk("R1 util", utilStat, 0);
    chk("R1 czOut", czOut, 0);
    chk("R1 lastAddr", lastAddr, 0);

    // R2/R4 arbitration vectors
    for (int i = 0; i < 10; i++) begin
      doReset();
      if (VEC[i][11:8] != 4'b0) pMask(VEC[i][11:8]);
      if (VEC[i][7:3] != 5'b0) pSet(VEC[i][7:3]);
      step(1);
      chk($sformatf("R2 vector %0d", i), curLevel, VEC[i][2:0]);
    end

    // R10 chain 4 -> 3 -> 2 -> 1 with R5 banking and R8 marks
    doReset();
    pSet(5'b01000); step(1);
    chk("R10 enter L4", curLevel, 4);
    chk("R3 grp2 prog L4", grp2, 4'b0100);
    pCz(2'b10);
    pSet(5'b00100); step(1);
    chk("R10 enter L3", curLevel, 3);
    chk("R5 fresh L3 pair", czOut, 2'b00);
    pCz(2'b01);
    pSet(5'b00010); step(1);
    chk("R10 enter L2", curLevel, 2);
    pCz(2'b10);
    pIo(); step(1);
    chk("R10 enter L1", curLevel, 1);
    chk("R8 util L2 mark", utilStat, 6'b000001);
    chk("R5 L1 pair", czOut, 2'b00);
    pCz(2'b11);
    pClr(5'b00001); pExit();
    chk("R10 back to L2", curLevel, 2);
    chk("R5 L2 pair kept", czOut, 2'b10);
    pClr(5'b00010); pExit();
    chk("R10 back to L3", curLevel, 3);
    chk("R5 L3 pair kept", czOut, 2'b01);
    pClr(5'b00100); pExit();
    chk("R10 back to L4", curLevel, 4);
    chk("R5 L4 pair kept", czOut, 2'b10);
    pExit();
    chk("R6 L4 stays with request set", curLevel, 4);
    pClr(5'b01000);
    chk("R3 clear prog L4", grp2, 4'b0000);
    pExit();
    chk("R6 fall back to L5", curLevel, 5);
    chk("R5 L5 pair", czOut, 2'b00);

    // R8 level 5 interrupted
    pCz(2'b01);
    pIo();
    chk("R3 grp1 set", grp1IoChk, 1);
    step(1);
    chk("R8 L1 over L5", curLevel, 1);
    chk("R8 util L5 mark and pair", utilStat, 6'b011000);
    pClr(5'b00001); pExit();
    chk("R5 L5 pair after return", czOut, 2'b01);

    // R7 level 5 exit raises service L4
    pExit();
    chk("R7 service bit set", grp2, 4'b1000);
    step(1);
    chk("R7 L4 runs", curLevel, 4);
    pClr(5'b10000);
    chk("R7 service cleared", grp2, 4'b0000);
    pExit();
    chk("R6 service L4 exit", curLevel, 5);

    // R3 set wins over clear
    reqSet = 5'b00100; reqClr = 5'b00100; step(1); reqSet = '0; reqClr = '0;
    chk("R3 set beats clear", grp2, 4'b0010);

    // R4 masked request held, then unmask
    doReset();
    pMask(4'b0010);
    pSet(5'b00100); step(1);
    chk("R4 masked L3 idle", curLevel, 5);
    chk("R4 request pending", grp2, 4'b0010);
    pMask(4'b0000);
    step(1);
    chk("R4 unmasked L3 runs", curLevel, 3);

    // R9 undefined input addresses
    doReset();
    pIn(8'h5F, 16'hBEEF);
    chk("R9 valid addr no request", grp1IoChk, 0);
    chk("R9 valid addr no capture", lastAddr, 16'h0000);
    step(1);
    chk("R9 valid addr level", curLevel, 5);
    pIn(8'h60, 16'h1234);
    chk("R9 capture", lastAddr, 16'h1234);
    chk("R9 request", grp1IoChk, 1);
    step(1);
    chk("R9 L1 runs", curLevel, 1);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule